// File: doc/BRIEF.md
# Flash Bank Erase Pulse Controller

This block runs one erase step on one bank of an on-chip flash array. It reads a control word that carries two enable bits, a bank-select field and a timer clock-control field. Setting both enable bits only arms the block. The erase itself begins when the write bus carries a command: a write to an even flash address whose data word equals that address. When the command is accepted, the block raises a busy flag. It then drives the erase-pulse line of the selected bank for a duration set by the clock-control field. While busy, it refuses array reads and instruction fetches.

When the pulse ends normally, the block moves on its own into erase-verify mode, which software can see on an output. Software polls the busy flag and runs the multi-pulse retry loop itself. A pulse setting longer than the permitted maximum is refused with an error flag. A loss of programming voltage during a pulse aborts the pulse and sets a sticky error flag.

The write bus is a valid/ready stream. `wr_ready` is always high, so a write is consumed on every cycle in which `wr_valid` is high, and the bus never sees back-pressure. A write that is not an acceptable erase command is dropped without any effect.

Top module: `erase_pulse_ctrl`

## Requirements
- R1: The block is in erase mode only when `ctl_word[0]` (write enable) and `ctl_word[1]` (erase enable) are both 1. A command written while either bit is 0 is ignored: `busy` stays 0.
- R2: A write counts as an erase command only when `wr_valid` is 1, `wr_addr[0]` is 0, and `wr_data` equals `wr_addr`. Any other write, including an odd address carrying equal data, is ignored.
- R3: `busy` is 1 from the clock edge at which a command is accepted. It stays 1 for exactly `BASE_CYC << ckctl` cycles, where ckctl is `ctl_word[7:4]`.
- R4: While `busy` is 1, exactly one bit of `erase_pulse` is 1: bit number `ctl_word[3:2]`. While `busy` is 0, `erase_pulse` is 0.
- R5: A command whose pulse length would exceed `MAX_CYC` cycles sets `width_err`, and no pulse is issued. A length equal to `MAX_CYC` is allowed.
- R6: `verify_mode` becomes 1 in the cycle after a pulse completes normally. It clears when a new command is accepted or when erase mode is left.
- R7: `rd_grant` equals `rd_req` while `busy` is 0, and is 0 while `busy` is 1.
- R8: If `vpp_ok` is 0 at an edge during a pulse, the pulse is aborted at that edge: `busy` goes to 0, `vpp_err` goes to 1 and `verify_mode` stays 0.
- R9: A command that arrives while `busy` is 1 is ignored. The running pulse neither restarts nor stretches.
- R10: The bank and the pulse length are captured when the command is accepted. Changes to `ctl_word` during a pulse do not affect that pulse.
- R11: `wr_ready` is 1 in every cycle after reset.
- R12: `width_err` and `vpp_err` stay set until erase mode is left or a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | CTL_W (8) | Control word: enables, bank select, clock-control |
| wr_valid | input | 1 | Write-bus beat valid |
| wr_ready | output | 1 | Write-bus ready, always 1 |
| wr_addr | input | ADDR_W (16) | Flash word address of the write |
| wr_data | input | ADDR_W (16) | Write data |
| vpp_ok | input | 1 | Programming voltage within limits |
| rd_req | input | 1 | Array read or fetch request |
| rd_grant | output | 1 | Read or fetch allowed |
| busy | output | 1 | Erase pulse in progress |
| erase_pulse | output | NUM_BANKS (4) | Per-bank erase pulse, one-hot while busy |
| verify_mode | output | 1 | Erase-verify mode entered |
| width_err | output | 1 | Requested pulse too long, sticky |
| vpp_err | output | 1 | Pulse aborted on voltage loss, sticky |

## Verification
The bench counts busy cycles at several clock-control settings, including the largest legal setting. A design that counts one cycle too many or too few, or that rejects the boundary value, shows up there. It sends near-miss commands: data one off from the address, an odd address carrying equal data, and commands with only one enable bit set. A decoder that is too permissive would start a pulse on one of these. It also re-issues a command in the middle of a pulse and rewrites the control word during a pulse, which catches designs that restart the timer or follow the live bank field. Finally, it drops the programming voltage part-way through a pulse. A design that entered verify mode anyway, or that failed to latch the error, would be reported.

// File: rtl/erase_pulse_pkg.sv
package erase_pulse_pkg;
  // control word bit positions that software depends on
  localparam int WEN_POS  = 0;
  localparam int EEN_POS  = 1;
  localparam int BANK_POS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_VERIFY = 2'd2
  } erase_st_t;
endpackage

// File: rtl/erase_ctl_decode.sv
module erase_ctl_decode #(
  parameter int NUM_BANKS = 4,
  parameter int CK_W      = 4,
  parameter int BASE_CYC  = 4,
  parameter int MAX_CYC   = 64,
  parameter int LEN_W     = 19,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CTL_W    = 2 + BANK_W + CK_W
) (
  input  logic [CTL_W-1:0]     ctl_word,
  output logic                 mode_on,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [LEN_W-1:0]     pulse_len,
  output logic                 len_bad
);
  import erase_pulse_pkg::*;

  localparam int CK_POS = BANK_POS + BANK_W;

  logic [BANK_W-1:0] bank_f;
  logic [CK_W-1:0]   ck_f;

  assign mode_on = ctl_word[WEN_POS] & ctl_word[EEN_POS];
  assign bank_f  = ctl_word[BANK_POS +: BANK_W];
  assign ck_f    = ctl_word[CK_POS +: CK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = (bank_f == BANK_W'(b));
  end

  assign pulse_len = LEN_W'(BASE_CYC) << ck_f;
  assign len_bad   = pulse_len > LEN_W'(MAX_CYC);
endmodule

// File: rtl/erase_cmd_match.sv
module erase_cmd_match #(
  parameter int ADDR_W = 16
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              cmd_hit
);
  assign cmd_hit = wr_valid & ~wr_addr[0] & (wr_data == wr_addr);
endmodule

// File: rtl/erase_pulse_seq.sv
module erase_pulse_seq #(
  parameter int NUM_BANKS = 4,
  parameter int LEN_W     = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_hit,
  input  logic                 mode_on,
  input  logic                 len_bad,
  input  logic [LEN_W-1:0]     pulse_len,
  input  logic [NUM_BANKS-1:0] bank_sel,
  input  logic                 vpp_ok,
  output logic                 busy,
  output logic                 verify_mode,
  output logic [NUM_BANKS-1:0] erase_pulse,
  output logic                 width_err,
  output logic                 vpp_err
);
  import erase_pulse_pkg::*;

  erase_st_t            st_q;
  logic [LEN_W-1:0]     cnt_q;
  logic [NUM_BANKS-1:0] bank_q;
  logic                 werr_q, verr_q;
  logic                 take, refuse;

  assign take   = cmd_hit & mode_on & (st_q != ST_PULSE);
  assign refuse = take & len_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bank_q <= '0;
      werr_q <= 1'b0;
      verr_q <= 1'b0;
    end else if (st_q == ST_PULSE) begin
      if (!vpp_ok) begin
        st_q   <= ST_IDLE;
        verr_q <= 1'b1;
      end else if (cnt_q == '0) begin
        st_q <= ST_VERIFY;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (refuse) begin
      st_q   <= ST_IDLE;
      werr_q <= 1'b1;
      verr_q <= 1'b0;
    end else if (take) begin
      st_q   <= ST_PULSE;
      cnt_q  <= pulse_len - 1'b1;
      bank_q <= bank_sel;
      werr_q <= 1'b0;
      verr_q <= 1'b0;
    end else if (!mode_on) begin
      st_q   <= ST_IDLE;
      werr_q <= 1'b0;
      verr_q <= 1'b0;
    end
  end

  assign busy        = (st_q == ST_PULSE);
  assign verify_mode = (st_q == ST_VERIFY);
  assign erase_pulse = busy ? bank_q : '0;
  assign width_err   = werr_q;
  assign vpp_err     = verr_q;
endmodule

// File: rtl/erase_pulse_ctrl.sv
module erase_pulse_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int CK_W      = 4,
  parameter int BASE_CYC  = 4,
  parameter int MAX_CYC   = 64,
  parameter int ADDR_W    = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CTL_W    = 2 + BANK_W + CK_W,
  localparam int LEN_W    = $clog2(BASE_CYC + 1) + (1 << CK_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CTL_W-1:0]     ctl_word,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic                 vpp_ok,
  input  logic                 rd_req,
  output logic                 rd_grant,
  output logic                 busy,
  output logic [NUM_BANKS-1:0] erase_pulse,
  output logic                 verify_mode,
  output logic                 width_err,
  output logic                 vpp_err
);
  logic                 mode_on, len_bad, cmd_hit;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [LEN_W-1:0]     pulse_len;

  erase_ctl_decode #(
    .NUM_BANKS(NUM_BANKS), .CK_W(CK_W), .BASE_CYC(BASE_CYC),
    .MAX_CYC(MAX_CYC), .LEN_W(LEN_W)
  ) u_dec (
    .ctl_word (ctl_word),
    .mode_on  (mode_on),
    .bank_sel (bank_sel),
    .pulse_len(pulse_len),
    .len_bad  (len_bad)
  );

  erase_cmd_match #(.ADDR_W(ADDR_W)) u_cmd (
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd_hit (cmd_hit)
  );

  erase_pulse_seq #(.NUM_BANKS(NUM_BANKS), .LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_hit    (cmd_hit),
    .mode_on    (mode_on),
    .len_bad    (len_bad),
    .pulse_len  (pulse_len),
    .bank_sel   (bank_sel),
    .vpp_ok     (vpp_ok),
    .busy       (busy),
    .verify_mode(verify_mode),
    .erase_pulse(erase_pulse),
    .width_err  (width_err),
    .vpp_err    (vpp_err)
  );

  assign wr_ready = 1'b1;
  assign rd_grant = rd_req & ~busy;
endmodule

// File: rtl/erase_pulse_ctrl_chk.sv
module erase_pulse_ctrl_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_ready,
  input logic                 vpp_ok,
  input logic                 rd_grant,
  input logic                 busy,
  input logic [NUM_BANKS-1:0] erase_pulse,
  input logic                 verify_mode,
  input logic                 width_err,
  input logic                 vpp_err
);
  // R4
  busy_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(erase_pulse) == 1);
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> erase_pulse == '0);
  // R7
  read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_grant);
  // R8
  vpp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vpp_ok) |=> (!busy && vpp_err && !verify_mode));
  // R6
  auto_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(vpp_ok)) |-> verify_mode);
  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_pulse));
  // R5
  width_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(width_err) |-> !busy);
  // R11
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind erase_pulse_ctrl erase_pulse_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .vpp_ok     (vpp_ok),
  .rd_grant   (rd_grant),
  .busy       (busy),
  .erase_pulse(erase_pulse),
  .verify_mode(verify_mode),
  .width_err  (width_err),
  .vpp_err    (vpp_err)
);

// File: tb/test_erase_pulse_ctrl.sv
module test_erase_pulse_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ctl_word = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        vpp_ok = 1'b1;
  logic        rd_req = 1'b0;
  logic        rd_grant, busy, verify_mode, width_err, vpp_err;
  logic [3:0]  erase_pulse;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  erase_pulse_ctrl i_erase_pulse_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_word(ctl_word),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .rd_req(rd_req), .rd_grant(rd_grant), .busy(busy),
    .erase_pulse(erase_pulse), .verify_mode(verify_mode),
    .width_err(width_err), .vpp_err(vpp_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctl(input int ck, input int bank, input logic [1:0] en);
    return {4'(ck), 2'(bank), en};
  endfunction

  // called at a negedge, returns at the next negedge
  task automatic send_wr(input logic [15:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(busy == 0, "R3 reset busy", int'(busy), 0);
    chk(erase_pulse == 0, "R4 reset pulse", int'(erase_pulse), 0);
    chk(verify_mode == 0 && width_err == 0 && vpp_err == 0, "R6 reset flags",
        int'({verify_mode, width_err, vpp_err}), 0);
    chk(wr_ready == 1, "R11 ready", int'(wr_ready), 1);
  endtask

  task automatic t_basic;
    int n;
    ctl_word = mk_ctl(0, 2, 2'b11);
    rd_req = 1'b1;
    send_wr(16'h0040, 16'h0040);
    chk(busy == 1, "R3 busy start", int'(busy), 1);
    chk(erase_pulse == 4'b0100, "R4 bank 2", int'(erase_pulse), 4);
    chk(rd_grant == 0, "R7 read refused", int'(rd_grant), 0);
    chk(wr_ready == 1, "R11 ready while busy", int'(wr_ready), 1);
    measure(n);
    chk(n == 4, "R3 length ck0", n, 4);
    chk(verify_mode == 1, "R6 verify entered", int'(verify_mode), 1);
    chk(erase_pulse == 0, "R4 pulse off", int'(erase_pulse), 0);
    chk(rd_grant == 1, "R7 read allowed", int'(rd_grant), 1);
    rd_req = 1'b0;
  endtask

  task automatic t_long;
    int n;
    ctl_word = mk_ctl(3, 1, 2'b11);
    send_wr(16'h1230, 16'h1230);
    chk(verify_mode == 0, "R6 verify cleared by command", int'(verify_mode), 0);
    chk(erase_pulse == 4'b0010, "R4 bank 1", int'(erase_pulse), 2);
    measure(n);
    chk(n == 32, "R3 length ck3", n, 32);
  endtask

  task automatic t_boundary;
    int n;
    ctl_word = mk_ctl(4, 3, 2'b11);
    send_wr(16'h0002, 16'h0002);
    chk(width_err == 0, "R5 max length allowed", int'(width_err), 0);
    chk(erase_pulse == 4'b1000, "R4 bank 3", int'(erase_pulse), 8);
    measure(n);
    chk(n == 64, "R5 length at max", n, 64);
  endtask

  task automatic t_mode_off;
    ctl_word = mk_ctl(0, 0, 2'b00);
    @(negedge clk);
    chk(verify_mode == 0, "R6 verify cleared on mode exit", int'(verify_mode), 0);
    ctl_word = mk_ctl(0, 0, 2'b01);
    send_wr(16'h0010, 16'h0010);
    chk(busy == 0, "R1 write-enable only", int'(busy), 0);
    ctl_word = mk_ctl(0, 0, 2'b10);
    send_wr(16'h0010, 16'h0010);
    chk(busy == 0, "R1 erase-enable only", int'(busy), 0);
  endtask

  task automatic t_mismatch;
    ctl_word = mk_ctl(0, 0, 2'b11);
    send_wr(16'h0040, 16'h0041);
    chk(busy == 0, "R2 data differs", int'(busy), 0);
    send_wr(16'h0041, 16'h0041);
    chk(busy == 0, "R2 odd address", int'(busy), 0);
  endtask

  task automatic t_width_err;
    ctl_word = mk_ctl(5, 0, 2'b11);
    send_wr(16'h0080, 16'h0080);
    chk(busy == 0, "R5 too long refused", int'(busy), 0);
    chk(width_err == 1, "R5 width flag", int'(width_err), 1);
    @(negedge clk);
    chk(width_err == 1, "R12 width flag sticky", int'(width_err), 1);
    ctl_word = '0;
    @(negedge clk);
    chk(width_err == 0, "R12 width flag cleared", int'(width_err), 0);
  endtask

  task automatic t_busy_ignored;
    int n;
    ctl_word = mk_ctl(2, 0, 2'b11);
    send_wr(16'h0100, 16'h0100);
    repeat (4) @(negedge clk);
    send_wr(16'h0200, 16'h0200);
    measure(n);
    chk(n == 11, "R9 no restart while busy", n, 11);
  endtask

  task automatic t_latch;
    int n;
    ctl_word = mk_ctl(1, 0, 2'b11);
    send_wr(16'h0300, 16'h0300);
    ctl_word = mk_ctl(4, 3, 2'b11);
    @(negedge clk);
    chk(erase_pulse == 4'b0001, "R10 bank held", int'(erase_pulse), 1);
    measure(n);
    chk(n == 7, "R10 length held", n, 7);
  endtask

  task automatic t_vpp_abort;
    int n;
    ctl_word = mk_ctl(2, 1, 2'b11);
    send_wr(16'h0400, 16'h0400);
    repeat (3) @(negedge clk);
    vpp_ok = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R8 pulse aborted", int'(busy), 0);
    chk(vpp_err == 1, "R8 vpp error set", int'(vpp_err), 1);
    chk(verify_mode == 0, "R8 no verify after abort", int'(verify_mode), 0);
    vpp_ok = 1'b1;
    @(negedge clk);
    chk(vpp_err == 1, "R12 vpp error sticky", int'(vpp_err), 1);
    ctl_word = mk_ctl(0, 1, 2'b11);
    send_wr(16'h0400, 16'h0400);
    chk(vpp_err == 0, "R12 vpp error cleared by command", int'(vpp_err), 0);
    measure(n);
    chk(n == 4, "R3 length after abort", n, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_long();
    t_boundary();
    t_mode_off();
    t_mismatch();
    t_width_err();
    t_busy_ignored();
    t_latch();
    t_vpp_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule